// File: doc/BRIEF.md
# Circular audio DMA address engine

This block produces the sequence of memory burst addresses for an audio stream that lives in a ring buffer. Software programs the ring bounds, the address of the first burst and a period length counted in bursts. While running, the engine offers one burst address at a time on a request/acknowledge pair and moves to the next burst slot after each acknowledge. After the final slot of the ring it goes back to the ring base. Every period of bursts, and every wrap, it records an event that can raise a level interrupt.

Software controls it through eight 32-bit word-aligned registers. Pending events are cleared by a clear field that acts for as long as it holds ones. A view register reads back either the live burst pointer or the burst counter. The memory transfers, the sample FIFO and the serial audio side sit outside this block.

Top module: `audio_ring_dma`

## Requirements
- R1: After each cycle with `brq_valid` and `brq_ack` both high, `brq_addr` advances by BURST_BYTES (default 8). In every other cycle it holds its value, unless the first-burst register is written.
- R2: When the acknowledged burst sits at the last-slot address (register 0x0C), the next burst address is the ring base (register 0x08).
- R3: A write to the first-burst register (0x10) loads that value as the next burst address and zeroes the burst counter. The ring base is used only on wraps.
- R4: Bit 0 of the control register (0x00) is the run bit, and `brq_valid` follows it from the cycle after the write. Setting it again resumes from the current pointer.
- R5: The period register (0x14) holds N. Every N-th acknowledged burst sets pending bit 0, and the burst counter then restarts at 0. With N = 0 the period event never fires.
- R6: An acknowledged burst at the last-slot address sets pending bit 1.
- R7: Control bits 1 and 2 enable pending bits 0 and 1. `irq` is high exactly while some pending bit has its enable set.
- R8: Clear register (0x04) bits [1:0] force the matching pending bits to zero and block new events while they stay 1. Events latch again once they are written back to 0.
- R9: Clear register bits [5:4] select what the view register (0x1C) returns: 0 gives the current burst address, 1 gives the burst counter, any other value gives zero.
- R10: After reset the run bit, the enables, the pending bits, the counter and the pointer are zero. `brq_valid` and `irq` are low.
- R11: `cfg_rdata` shows the register at byte offset `cfg_addr` (bits [4:2] used) one clock after the address is presented. The status register (0x18) holds the pending bits in [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| brq_valid | output | 1 | Burst request |
| brq_addr | output | 32 | Burst address |
| brq_ack | input | 1 | Burst accepted by memory side |
| irq | output | 1 | Level interrupt |

## Verification
The sweep covers ring lengths from one to four slots, period lengths from zero to three, and every first-burst slot. Acknowledges arrive either back to back or every other cycle. Back-to-back acknowledges check the step and the wrap. Gapped acknowledges show that the pointer holds between bursts. Varying the start slot separates the first-burst register from the ring base. Further runs pause and resume, hold the clear bits through events, toggle the enables with events already pending, and read every view selection, so that each control field can be told apart from the others.

// File: rtl/ardma_pkg.sv
package ardma_pkg;
  localparam int NSRC   = 2;
  localparam int SRC_PERIOD = 0;
  localparam int SRC_WRAP   = 1;
  localparam int RAW    = 5;

  typedef enum logic [2:0] {
    RG_CTRL   = 3'd0,
    RG_CLR    = 3'd1,
    RG_START  = 3'd2,
    RG_FINISH = 3'd3,
    RG_INIT   = 3'd4,
    RG_PERIOD = 3'd5,
    RG_STATUS = 3'd6,
    RG_VIEW   = 3'd7
  } reg_idx_e;

  typedef enum logic [1:0] {
    VIEW_PTR = 2'd0,
    VIEW_CNT = 2'd1
  } view_sel_e;
endpackage

// File: rtl/ardma_regs.sv
module ardma_regs
  import ardma_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [RAW-1:0]  cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  output logic            run,
  output logic [NSRC-1:0] ien,
  output logic [NSRC-1:0] clr,
  output logic [DW-1:0]   start_a,
  output logic [DW-1:0]   finish_a,
  output logic [CW-1:0]   period_n,
  output logic            init_load,
  input  logic [DW-1:0]   cur_addr,
  input  logic [CW-1:0]   cnt,
  input  logic [NSRC-1:0] pend
);
  reg_idx_e    idx;
  view_sel_e   vsel;
  logic [DW-1:0] init_q;
  logic [DW-1:0] rd_nxt;

  assign idx       = reg_idx_e'(cfg_addr[RAW-1:2]);
  assign init_load = cfg_we && (idx == RG_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      ien      <= '0;
      clr      <= '0;
      vsel     <= VIEW_PTR;
      start_a  <= '0;
      finish_a <= '0;
      init_q   <= '0;
      period_n <= '0;
    end else if (cfg_we) begin
      case (idx)
        RG_CTRL: begin
          run <= cfg_wdata[0];
          ien <= cfg_wdata[NSRC:1];
        end
        RG_CLR: begin
          clr  <= cfg_wdata[NSRC-1:0];
          vsel <= view_sel_e'(cfg_wdata[5:4]);
        end
        RG_START:  start_a  <= cfg_wdata;
        RG_FINISH: finish_a <= cfg_wdata;
        RG_INIT:   init_q   <= cfg_wdata;
        RG_PERIOD: period_n <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_nxt = '0;
    case (idx)
      RG_CTRL: begin
        rd_nxt[0]      = run;
        rd_nxt[NSRC:1] = ien;
      end
      RG_CLR: begin
        rd_nxt[NSRC-1:0] = clr;
        rd_nxt[5:4]      = vsel;
      end
      RG_START:  rd_nxt = start_a;
      RG_FINISH: rd_nxt = finish_a;
      RG_INIT:   rd_nxt = init_q;
      RG_PERIOD: rd_nxt[CW-1:0] = period_n;
      RG_STATUS: rd_nxt[NSRC-1:0] = pend;
      RG_VIEW: begin
        if (vsel == VIEW_PTR)      rd_nxt = cur_addr;
        else if (vsel == VIEW_CNT) rd_nxt[CW-1:0] = cnt;
      end
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/ardma_addr_gen.sv
module ardma_addr_gen #(
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int BURST_BYTES = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ack,
  input  logic [DW-1:0] start_a,
  input  logic [DW-1:0] finish_a,
  input  logic [CW-1:0] period_n,
  input  logic          init_load,
  input  logic [DW-1:0] init_val,
  output logic          brq_valid,
  output logic [DW-1:0] cur_addr,
  output logic [CW-1:0] cnt,
  output logic          ev_period,
  output logic          ev_wrap
);
  localparam logic [DW-1:0] STEP = DW'(BURST_BYTES);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic fire, at_end, cnt_hit;

  assign brq_valid = run;
  assign fire      = run && ack && !init_load;
  assign at_end    = (cur_addr == finish_a);
  assign cnt_hit   = (period_n != '0) && (cnt == period_n - ONE);
  assign ev_wrap   = fire && at_end;
  assign ev_period = fire && cnt_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      cnt      <= '0;
    end else if (init_load) begin
      cur_addr <= init_val;
      cnt      <= '0;
    end else if (fire) begin
      cur_addr <= at_end ? start_a : cur_addr + STEP;
      cnt      <= cnt_hit ? '0 : cnt + ONE;
    end
  end
endmodule

// File: rtl/ardma_irq.sv
module ardma_irq
  import ardma_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] ien,
  output logic [NSRC-1:0] pend,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst || clr[i]) pend[i] <= 1'b0;
      else if (ev[i])    pend[i] <= 1'b1;
    end
  end

  assign irq = |(pend & ien);
endmodule

// File: rtl/audio_ring_dma.sv
module audio_ring_dma
  import ardma_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int BURST_BYTES = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_we,
  input  logic [RAW-1:0] cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  output logic           brq_valid,
  output logic [DW-1:0]  brq_addr,
  input  logic           brq_ack,
  output logic           irq
);
  logic            run;
  logic [NSRC-1:0] ien, clr_q, pend, ev;
  logic [DW-1:0]   start_a, finish_a, cur_addr;
  logic [CW-1:0]   period_n, cnt;
  logic            init_load, ev_period, ev_wrap;

  ardma_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .run(run), .ien(ien),
    .clr(clr_q), .start_a(start_a), .finish_a(finish_a),
    .period_n(period_n), .init_load(init_load), .cur_addr(cur_addr),
    .cnt(cnt), .pend(pend)
  );

  ardma_addr_gen #(.DW(DW), .CW(CW), .BURST_BYTES(BURST_BYTES)) u_addr (
    .clk(clk), .rst(rst), .run(run), .ack(brq_ack), .start_a(start_a),
    .finish_a(finish_a), .period_n(period_n), .init_load(init_load),
    .init_val(cfg_wdata), .brq_valid(brq_valid), .cur_addr(cur_addr),
    .cnt(cnt), .ev_period(ev_period), .ev_wrap(ev_wrap)
  );

  always_comb begin
    ev = '0;
    ev[SRC_PERIOD] = ev_period;
    ev[SRC_WRAP]   = ev_wrap;
  end

  ardma_irq u_irq (
    .clk(clk), .rst(rst), .ev(ev), .clr(clr_q), .ien(ien),
    .pend(pend), .irq(irq)
  );

  assign brq_addr = cur_addr;
endmodule

// File: rtl/ardma_chk.sv
module ardma_chk #(
  parameter int DW          = 32,
  parameter int BURST_BYTES = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we,
  input logic [4:0]    cfg_addr,
  input logic [DW-1:0] cfg_wdata,
  input logic          brq_valid,
  input logic          brq_ack,
  input logic [DW-1:0] brq_addr,
  input logic [DW-1:0] start_a,
  input logic [DW-1:0] finish_a,
  input logic [1:0]    clr_q,
  input logic          irq
);
  logic init_wr, stop_wr, hs;
  assign init_wr = cfg_we && (cfg_addr[4:2] == 3'd4);
  assign stop_wr = cfg_we && (cfg_addr[4:2] == 3'd0) && !cfg_wdata[0];
  assign hs      = brq_valid && brq_ack;

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (hs && brq_addr != finish_a && !init_wr) |=> brq_addr == $past(brq_addr) + DW'(BURST_BYTES));

  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    (!hs && !init_wr) |=> $stable(brq_addr));

  a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
    (hs && brq_addr == finish_a && !init_wr) |=> brq_addr == $past(start_a));

  a_r3_init: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> brq_addr == $past(cfg_wdata));

  a_r4_stop: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> !brq_valid);

  a_r8_clear: assert property (@(posedge clk) disable iff (rst)
    (&clr_q) |=> !irq);
endmodule

bind audio_ring_dma ardma_chk #(.DW(DW), .BURST_BYTES(BURST_BYTES)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .brq_valid(brq_valid), .brq_ack(brq_ack),
  .brq_addr(brq_addr), .start_a(start_a), .finish_a(finish_a),
  .clr_q(clr_q), .irq(irq)
);

// File: tb/sim_audio_ring_dma.sv
`timescale 1ns/1ps
module sim_audio_ring_dma;
  localparam int B = 8;
  localparam logic [31:0] BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        brq_valid, brq_ack = 1'b0, irq;
  logic [31:0] brq_addr;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  // ring model
  int ring_len, slot, per_n, cnt_m;
  bit pe0, pe1;

  audio_ring_dma u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .brq_valid(brq_valid),
    .brq_addr(brq_addr), .brq_ack(brq_ack), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  function automatic logic [31:0] exp_addr();
    return BASE + 32'(slot * B);
  endfunction

  task automatic bursts(input int m, input bit gap);
    for (int j = 0; j < m; j++) begin
      if (gap) begin
        chk("R1 hold", brq_addr, exp_addr());
        @(negedge clk);
      end
      chk("R4 valid", {31'b0, brq_valid}, 32'd1);
      chk(slot == 0 ? "R2 wrap/R3 addr" : "R1 step", brq_addr, exp_addr());
      brq_ack = 1'b1;
      @(negedge clk);
      brq_ack = 1'b0;
      if (slot == ring_len - 1) pe1 = 1'b1;
      slot = (slot + 1) % ring_len;
      if (per_n == 0) cnt_m = (cnt_m + 1) % 65536;
      else if (cnt_m + 1 == per_n) begin cnt_m = 0; pe0 = 1'b1; end
      else cnt_m = cnt_m + 1;
    end
  endtask

  task automatic observe();
    logic [31:0] d;
    rd(5'h18, d);
    chk("R5 R6 status", d, {30'b0, pe1, pe0});
    chk("R7 irq", {31'b0, irq}, {31'b0, pe0 | pe1});
    rd(5'h1C, d);
    chk("R9 view ptr", d, exp_addr());
    wr(5'h04, 32'h10);
    rd(5'h1C, d);
    chk("R5 R9 view cnt", d, 32'(cnt_m));
    wr(5'h04, 32'h00);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk("R10 valid", {31'b0, brq_valid}, 32'd0);
    chk("R10 irq", {31'b0, irq}, 32'd0);
    rd(5'h00, d); chk("R10 ctrl", d, 32'd0);
    rd(5'h18, d); chk("R10 status", d, 32'd0);
    rd(5'h1C, d); chk("R10 ptr", d, 32'd0);
    // R11 register readback
    wr(5'h08, 32'hCAFE_0008);
    rd(5'h08, d); chk("R11 start readback", d, 32'hCAFE_0008);

    for (int L = 1; L <= 4; L++) begin
      for (int N = 0; N <= 3; N++) begin
        ring_len = L; per_n = N;
        slot = (L + N) % L; cnt_m = 0; pe0 = 1'b0; pe1 = 1'b0;
        wr(5'h04, 32'h3);
        wr(5'h04, 32'h0);
        wr(5'h08, BASE);
        wr(5'h0C, BASE + 32'((L - 1) * B));
        wr(5'h14, 32'(N));
        wr(5'h10, exp_addr());
        wr(5'h00, 32'h7);
        bursts(2 * L + 3, ((L + N) % 2) == 1);
        wr(5'h00, 32'h6);
        chk("R4 stop", {31'b0, brq_valid}, 32'd0);
        repeat (2) @(negedge clk);
        chk("R1 hold stopped", brq_addr, exp_addr());
        observe();
        // R4 resume continues from the current pointer
        wr(5'h00, 32'h7);
        bursts(2, 1'b0);
        wr(5'h00, 32'h6);
        observe();
      end
    end

    // R8 clear bits held through events
    ring_len = 4; per_n = 1; slot = 0; cnt_m = 0; pe0 = 1'b0; pe1 = 1'b0;
    wr(5'h04, 32'h3);
    wr(5'h0C, BASE + 32'(3 * B));
    wr(5'h14, 32'd1);
    wr(5'h10, BASE);
    wr(5'h00, 32'h7);
    bursts(4, 1'b0);
    wr(5'h00, 32'h6);
    rd(5'h18, d); chk("R8 held clear status", d, 32'd0);
    chk("R8 held clear irq", {31'b0, irq}, 32'd0);
    wr(5'h04, 32'h0);
    pe0 = 1'b0; pe1 = 1'b0;
    wr(5'h00, 32'h7);
    bursts(1, 1'b0);
    wr(5'h00, 32'h6);
    rd(5'h18, d); chk("R8 relatch status", d, 32'h1);

    // R7 enables gate the interrupt
    wr(5'h00, 32'h0);
    chk("R7 no enable", {31'b0, irq}, 32'd0);
    wr(5'h00, 32'h4);
    chk("R7 wrap-only enable", {31'b0, irq}, 32'd0);
    wr(5'h00, 32'h2);
    chk("R7 period enable", {31'b0, irq}, 32'd1);

    // R9 unused selection reads zero
    wr(5'h04, 32'h20);
    rd(5'h1C, d); chk("R9 view other", d, 32'd0);
    wr(5'h04, 32'h30);
    rd(5'h1C, d); chk("R9 view other3", d, 32'd0);

    // R3 first-burst write zeroes counter and sets pointer
    wr(5'h10, BASE + 32'(2 * B));
    wr(5'h04, 32'h10);
    rd(5'h1C, d); chk("R3 cnt zero", d, 32'd0);
    wr(5'h04, 32'h00);
    rd(5'h1C, d); chk("R3 pointer", d, BASE + 32'(2 * B));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule